// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. It decides whether an embedded program or erase has finished. After a start pulse it issues status reads one at a time and groups them into pairs that do not overlap. It compares the toggle bit (bit 6) of the two reads in a pair: a value that holds still means the operation has ended. When the toggle bit keeps flipping, the poller looks at the failure flag (bit 5) of the later read. If that flag is high, one more pair settles the outcome: a bit that has stopped flipping means success, and a bit that still flips means failure.

On a failure the block also pulses a request for a reset command, so that the surrounding logic can send the device back to array-read mode. A programmable limit caps the number of pairs that decide nothing. When the cap is reached, the block reports a watchdog failure, which is kept apart from the bit-5 failure. The host can abort at any time. The next start then begins again with a fresh first read.

Reads go out over a valid/ready request channel and come back over a valid/ready response channel. The request valid stays high until ready is seen, and it cannot be withdrawn while it waits. Only one read is ever outstanding. The response ready is high only while that read is awaited, so the responder applies back-pressure simply by holding its valid. After an abort the read agent must drop any read already accepted.

Top module: `toggle_poller`

## Requirements
- R1: After reset, busy, done, fail, wdog_fail, rst_cmd_req, rd_req_valid and rd_rsp_ready are all low.
- R2: A start pulse while idle raises rd_req_valid on the next cycle. A start pulse while busy has no effect on the reads or on the outcome.
- R3: Once raised, rd_req_valid stays high until rd_req_ready is seen. rd_rsp_ready is high only while the accepted read is awaited, and no new request is raised until its response has been taken. At most one read is outstanding.
- R4: Reads form non-overlapping pairs, starting with the first read after start. If bit 6 (mask 0x40) is equal in both reads of a pair, the block reports success: fail=0 and wdog_fail=0.
- R5: If bit 6 differs and bit 5 (mask 0x20) of the later read is low, the block starts a new pair. Bit 5 of the earlier read is ignored.
- R6: If bit 6 differs and bit 5 of the later read is high, exactly one more pair is read, and the poll limit does not cut that pair short. If bit 6 is equal in that pair, the result is success. If it still differs, the result is fail=1, with rst_cmd_req high in the done cycle.
- R7: A pair that decides nothing and does not carry bit 5 high, and that brings the count of undecided pairs up to max_polls, ends the run with wdog_fail=1 and fail=0, and without rst_cmd_req. A max_polls of 0 behaves as 1.
- R8: done is high for exactly one cycle, and busy is already low in that cycle. fail and wdog_fail never go high together, and they keep their values until the next accepted start.
- R9: abort returns the block to idle without a done pulse. The next start begins from a fresh first read, and no earlier read is carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| abort | input | 1 | Stop polling and return to idle |
| max_polls | input | CNT_W | Limit on undecided pairs (0 acts as 1) |
| rd_req_valid | output | 1 | Status read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Status byte valid |
| rd_rsp_data | input | DATA_W | Returned status byte |
| rd_rsp_ready | output | 1 | Poller awaits a status byte |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Bit-5 failure confirmed |
| wdog_fail | output | 1 | Poll limit reached |
| rst_cmd_req | output | 1 | Request to write the reset command |

## Verification
A wrong pair phase, where the second read is taken as a first, shows up as a changed read count or a different verdict at the very next done pulse. A confirm flag that is lost or stuck turns a bit-5 case into a watchdog result, or into a result one pair early, and the outcome bits show this within two pairs. A wrong undecided-pair count shows as a done pulse that comes at the wrong read count. A fault in the handshake breaks the pairing of requests and responses, and the read count reveals it on the same run.

// File: rtl/tglp_pkg.sv
package tglp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} tglp_state_t;
  typedef enum logic [1:0] {VD_NONE, VD_OK, VD_FAIL, VD_WDOG} tglp_verdict_t;
endpackage

// File: rtl/tglp_pair_cmp.sv
module tglp_pair_cmp #(
  parameter int DATA_W  = 8,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] data,
  output logic              pair_done,
  output logic              pair_same,
  output logic              pair_err,
  output logic              confirm
);
  logic second_q, first_tog_q, confirm_q;

  assign pair_done = capture && second_q;
  assign pair_same = (first_tog_q == data[TOG_BIT]);
  assign pair_err  = data[ERR_BIT];
  assign confirm   = confirm_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      second_q    <= 1'b0;
      first_tog_q <= 1'b0;
      confirm_q   <= 1'b0;
    end else if (capture) begin
      if (!second_q) begin
        first_tog_q <= data[TOG_BIT];
        second_q    <= 1'b1;
      end else begin
        second_q <= 1'b0;
        if (!pair_same && !confirm_q && data[ERR_BIT]) confirm_q <= 1'b1;
      end
    end
  end

  // R4: pairs never overlap, so a completed pair leaves the phase at "first"
  assert_pair_nonoverlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && !clear) |=> !second_q);
  // R6: confirm is only ever set at the end of a pair
  assert_confirm_on_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(confirm_q) |-> $past(pair_done));
endmodule

// File: rtl/tglp_poll_cnt.sv
module tglp_poll_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam int WIDE_W = CNT_W + 1;
  logic [WIDE_W-1:0] cnt_q, eff_limit, cnt_next;

  assign eff_limit = (limit == '0) ? WIDE_W'(1) : {1'b0, limit};
  assign cnt_next  = cnt_q + WIDE_W'(1);
  assign expired   = (cnt_next >= eff_limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step && !cnt_q[CNT_W]) cnt_q <= cnt_next;
  end

  // R7: the count of undecided pairs moves by at most one per cycle
  assert_cnt_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !$past(clear)) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + WIDE_W'(1)));
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import tglp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              rd_rsp_ready,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              wdog_fail,
  output logic              rst_cmd_req
);
  tglp_state_t   state_q;
  tglp_verdict_t verdict;
  logic start_acc, capture, clear;
  logic pair_done, pair_same, pair_err, confirm, expired, step;
  logic done_q, fail_q, wdog_q, rstc_q;

  assign start_acc = (state_q == ST_IDLE) && start && !abort;
  assign clear     = start_acc || abort;
  assign capture   = (state_q == ST_WAIT) && rd_rsp_valid && !abort;

  tglp_pair_cmp #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) i_cmp (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture), .data(rd_rsp_data),
    .pair_done(pair_done), .pair_same(pair_same), .pair_err(pair_err), .confirm(confirm));

  tglp_poll_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .limit(max_polls), .expired(expired));

  always_comb begin
    verdict = VD_NONE;
    if (pair_done) begin
      if (pair_same)     verdict = VD_OK;
      else if (confirm)  verdict = VD_FAIL;
      else if (pair_err) verdict = VD_NONE;
      else if (expired)  verdict = VD_WDOG;
    end
  end
  assign step = pair_done && (verdict == VD_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      wdog_q  <= 1'b0;
      rstc_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rstc_q <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_REQ;
            fail_q  <= 1'b0;
            wdog_q  <= 1'b0;
          end
          ST_REQ: if (rd_req_ready) state_q <= ST_WAIT;
          ST_WAIT: if (rd_rsp_valid) begin
            if (verdict == VD_NONE) begin
              state_q <= ST_REQ;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              fail_q  <= (verdict == VD_FAIL);
              wdog_q  <= (verdict == VD_WDOG);
              rstc_q  <= (verdict == VD_FAIL);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_rsp_ready = (state_q == ST_WAIT);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign fail         = fail_q;
  assign wdog_fail    = wdog_q;
  assign rst_cmd_req  = rstc_q;

  // R2: an accepted start raises the read request on the next cycle
  assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort) |=> rd_req_valid);
  // R3: a pending request is held until it is accepted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !abort) |=> rd_req_valid);
  // R3: never a request while a response is awaited
  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
  // R8: done is a single-cycle pulse taken while not busy
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_codes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail && wdog_fail));
  // R6: the reset-command request only accompanies a failure verdict
  assert_rstcmd_with_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_req |-> (done && fail));
  // R9: abort leaves the block idle without completing
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));
endmodule

// File: tb/test_toggle_poller.sv
module test_toggle_poller;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, abort = 1'b0;
  logic [7:0] max_polls = 8'd4;
  logic       rd_req_valid, rd_req_ready = 1'b0;
  logic       rd_rsp_valid = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;
  logic       rd_rsp_ready, busy, done, fail, wdog_fail, rst_cmd_req;

  int checks = 0, errors = 0;
  int cycles = 0;
  logic [7:0] seq [64];
  int  rsp_cnt = 0, base = 0;
  bit  pend = 1'b0, rdy_en = 1'b1;

  always #5 clk = ~clk;

  toggle_poller i_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .max_polls(max_polls),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_ready(rd_rsp_ready),
    .busy(busy), .done(done), .fail(fail), .wdog_fail(wdog_fail), .rst_cmd_req(rst_cmd_req));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_req_valid && rd_req_ready) pend <= 1'b1;
    if (rd_rsp_valid && rd_rsp_ready) begin
      pend    <= 1'b0;
      rsp_cnt <= rsp_cnt + 1;
    end
  end

  always @(negedge clk) begin
    rd_req_ready = rdy_en && ($urandom % 4 != 0);
    rd_rsp_valid = pend && ($urandom % 3 != 0);
    rd_rsp_data  = seq[(rsp_cnt - base) & 63];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int lim, output int code, output int nreads);
    int eff = (lim == 0) ? 1 : lim;
    int pairs = 0;
    bit conf = 1'b0;
    code = -1; nreads = 0;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] a = seq[2*i];
      logic [7:0] b = seq[2*i+1];
      nreads = 2*i + 2;
      if (a[6] == b[6]) begin code = 0; return; end
      if (conf) begin code = 1; return; end
      pairs++;
      if (b[5]) conf = 1'b1;
      else if (pairs >= eff) begin code = 2; return; end
    end
  endfunction

  task automatic set_pair(input int k, input bit tog, input bit err);
    logic [7:0] a = 8'($urandom);
    logic [7:0] b = 8'($urandom);
    b[6] = tog ? ~a[6] : a[6];
    b[5] = err;
    seq[2*k] = a; seq[2*k+1] = b;
  endtask

  task automatic run(input int lim, input string tag, input bit restart_mid);
    int code, nreads, wait_n;
    int got;
    model(lim, code, nreads);
    @(negedge clk);
    max_polls = 8'(lim);
    base = rsp_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_req_valid || busy, {tag, " R2 start"}, int'(busy), 1);
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 1000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done, {tag, " R8 done seen"}, int'(done), 1);
    got = done ? (fail ? 1 : (wdog_fail ? 2 : 0)) : -1;
    chk(got == code, {tag, (code == 2) ? " R7 verdict" : (code == 1 ? " R6 verdict" : " R4 verdict")}, got, code);
    chk(rsp_cnt - base == nreads, {tag, " R5 read count"}, rsp_cnt - base, nreads);
    chk(rst_cmd_req == (code == 1), {tag, " R6 reset request"}, int'(rst_cmd_req), int'(code == 1));
    chk(!busy, {tag, " R8 idle at done"}, int'(busy), 0);
    @(negedge clk);
    chk(!done, {tag, " R8 one-cycle done"}, int'(done), 0);
    chk(fail == (code == 1) && wdog_fail == (code == 2), {tag, " R8 code held"},
        {30'd0, fail, wdog_fail}, (code == 1) ? 2 : ((code == 2) ? 1 : 0));
  endtask

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 64; i++) seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !wdog_fail && !rst_cmd_req && !rd_req_valid && !rd_rsp_ready,
        "R1 reset state", {25'd0, busy, done, fail, wdog_fail, rst_cmd_req, rd_req_valid, rd_rsp_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    set_pair(0, 0, 1);                       // R4 immediate; bit 5 on a stable pair
    run(4, "first-pair", 0);
    set_pair(0, 1, 0); set_pair(1, 1, 0); set_pair(2, 0, 0);
    seq[4][5] = 1'b1;                        // R5 earlier read's bit 5 ignored
    run(5, "toggles-then-stop", 0);
    set_pair(0, 1, 1); set_pair(1, 0, 0);
    run(4, "err-then-stop", 0);              // R6 success after bit 5
    set_pair(0, 1, 0); set_pair(1, 1, 1); set_pair(2, 1, 0);
    run(6, "err-still-toggles", 0);          // R6 fail
    for (int k = 0; k < 5; k++) set_pair(k, 1, 0);
    run(3, "limit-three", 0);                // R7
    run(0, "limit-zero", 0);                 // R7 zero acts as one
    set_pair(0, 1, 0); set_pair(1, 1, 1); set_pair(2, 1, 0);
    run(2, "err-at-limit", 0);               // R6 confirm pair runs past the limit
    for (int k = 0; k < 4; k++) set_pair(k, 1, 0);
    set_pair(4, 0, 0);
    run(8, "start-while-busy", 1);           // R2 extra start ignored

    // R9 abort after one read, then restart from a fresh first read
    seq[0] = 8'h40; seq[1] = 8'h40;
    @(negedge clk);
    max_polls = 8'd4; base = rsp_cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (rsp_cnt - base < 1) @(negedge clk);
    rdy_en = 1'b0;
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!busy && !done, "R9 abort idle", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(!done && !rd_req_valid, "R9 no done after abort", int'(done), 0);
    rdy_en = 1'b1;
    seq[0] = 8'h00; seq[1] = 8'h00;
    run(4, "after-abort R9", 0);

    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < 32; k++) set_pair(k, ($urandom % 10) < 7, ($urandom % 10) == 0);
      run(int'($urandom % 7), "random", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule